// File: doc/BRIEF.md
# Ethernet Transmit Frame Staging Buffer

This block holds exactly one outgoing Ethernet frame between a host register port and a MAC transmit engine. The host loads the frame as 32-bit words. The low half of the first word carries the frame length, and the frame bytes follow, packed least significant byte first. A start command then plays the frame out on a byte-wide valid/ready stream, and the final byte carries an end marker.

When padding is enabled and the stated length is below the Ethernet minimum, the block appends zero bytes until the frame reaches that minimum. The pad bytes come from logic and never from the buffer, so data left over from an earlier, longer frame cannot appear on the wire. A busy flag covers the whole playout. A one-cycle done pulse follows the last accepted byte, and the load pointer then returns to the start of the buffer for the next frame.

Top module: `tx_frame_stage`

## Requirements
- R1: In the first word written, bits 15:0 hold the frame length, with bits 7:0 as its low byte. Frame byte 0 sits in bits 23:16 and frame byte 1 in bits 31:24. Each later word supplies four frame bytes in the order bits 7:0, 15:8, 23:16, 31:24.
- R2: A start pulse while idle raises `busy` and `tx_valid` on the next cycle. Frame bytes are then presented in order, and `busy` stays high until the final byte is accepted.
- R3: `tx_last` is high on the final byte of a frame and on no other byte.
- R4: While `tx_valid` is high and `tx_ready` is low, the presented byte and its end marker stay unchanged. No byte is lost or repeated.
- R5: With `pad_en` high at start and a length below 60, exactly 60 bytes are sent. Every byte at position `length` or beyond is zero, even when the buffer holds nonzero data from an earlier frame.
- R6: With `pad_en` low, or with a length of 60 or more, exactly `length` bytes are sent.
- R7: A length of zero with padding off produces no output byte. It gives a `done` pulse on the cycle after start, and `busy` never rises.
- R8: `done` is high for one cycle, on the cycle after the final byte is accepted. The next word written is then treated as the first word of a new frame.
- R9: A host write while `busy` is high is ignored and sets `err`, which stays high until reset.
- R10: The buffer holds 2048 bytes (512 words). Further writes before a transmission are dropped and alter no stored byte.
- R11: After reset, `busy`, `tx_valid`, `tx_last`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host write word |
| pad_en | input | 1 | Pad short frames to minimum, sampled at start |
| start | input | 1 | Begin transmission of the loaded frame |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Downstream accepts byte |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag for writes during transmission |

## Verification
The hardest cases to reach from the ports are zero padding over stale data and the full-buffer boundary. For the first, the bench sends a long frame with nonzero contents, then a short padded frame, so the buffer positions past the new length still hold old bytes that must not leak. For the second, it writes 520 words behind a short length field and checks that the eight surplus writes never reach the first word. It also sends a full 2046-byte frame under pseudo-random `tx_ready` stalls to exercise the end of the address range under backpressure.

// File: rtl/tx_frame_stage.sv
module tx_frame_stage #(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        pad_en,
  input  logic        start,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int AW    = $clog2(BUF_BYTES);
  localparam int WW    = $clog2(WORDS);

  logic [31:0]   mem [WORDS];
  logic [WW:0]   wcnt;
  logic [15:0]   len, tot, idx;
  logic          full, wr_ok;
  logic [AW-1:0] rpos;
  logic [31:0]   rword, shifted;
  logic [15:0]   tot_n;

  assign full  = (wcnt == (WW+1)'(WORDS));
  assign wr_ok = wr_en && !busy && !full;
  assign tot_n = (pad_en && len < 16'(MIN_LEN)) ? 16'(MIN_LEN) : len;

  assign rpos     = AW'(idx + 16'd2);
  assign rword    = mem[rpos[AW-1:2]];
  assign shifted  = rword >> {rpos[1:0], 3'b000};
  assign tx_data  = (idx < len) ? shifted[7:0] : 8'h00;
  assign tx_valid = busy;
  assign tx_last  = busy && (idx == tot - 16'd1);

  always_ff @(posedge clk)
    if (wr_ok) mem[wcnt[WW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      wcnt <= '0;
      len  <= '0;
      tot  <= '0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (wr_en && busy) err <= 1'b1;
      if (wr_ok) begin
        wcnt <= wcnt + 1'b1;
        if (wcnt == '0) len <= wr_data[15:0];
      end
      if (busy) begin
        if (tx_ready) begin
          if (tx_last) begin
            busy <= 1'b0;
            done <= 1'b1;
            wcnt <= '0;
            len  <= '0;
          end else begin
            idx <= idx + 16'd1;
          end
        end
      end else if (start) begin
        tot <= tot_n;
        idx <= '0;
        if (tot_n == '0) begin
          done <= 1'b1;
          wcnt <= '0;
          len  <= '0;
        end else begin
          busy <= 1'b1;
        end
      end
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < tot);
  assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_wr_busy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/tb_tx_frame_stage.sv
`timescale 1ns/1ps
module tb_tx_frame_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pad_en = 1'b0;
  logic        start = 1'b0;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, busy, done, err;

  int checks = 0;
  int errors = 0;

  tx_frame_stage dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pad_en(pad_en), .start(start), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .busy(busy), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [7:0] mbytes [2048];
  int         m_wcnt = 0;
  int         m_len = 0;
  bit         m_busy = 0, m_done = 0, m_err = 0;
  logic [7:0] q [$];
  int         nacc = 0;
  bit         monitor_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wcnt = 0; m_len = 0; m_busy = 0; m_done = 0; m_err = 0; q.delete();
    end else begin
      m_done = 0;
      if (wr_en) begin
        if (m_busy) m_err = 1;
        else if (m_wcnt < 512) begin
          for (int l = 0; l < 4; l++) mbytes[m_wcnt*4+l] = wr_data[8*l +: 8];
          if (m_wcnt == 0) m_len = int'(wr_data[15:0]);
          m_wcnt++;
        end
      end
      if (m_busy) begin
        if (tx_ready) begin
          void'(q.pop_front());
          nacc++;
          if (q.size() == 0) begin
            m_busy = 0; m_done = 1; m_wcnt = 0; m_len = 0;
          end
        end
      end else if (start) begin
        int total;
        total = (pad_en && m_len < 60) ? 60 : m_len;
        for (int i = 0; i < total; i++)
          q.push_back(i < m_len ? mbytes[(i+2) & 2047] : 8'h00);
        if (total == 0) begin
          m_done = 1; m_wcnt = 0; m_len = 0;
        end else m_busy = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(tx_valid == m_busy, "R2 tx_valid", tx_valid, m_busy);
      if (m_busy) begin
        chk(tx_data == q[0], "R1 R4 R5 tx_data", tx_data, q[0]);
        chk(tx_last == (q.size() == 1), "R3 tx_last", tx_last, q.size() == 1);
      end else
        chk(tx_last == 1'b0, "R3 tx_last idle", tx_last, 0);
      chk(done == m_done, "R8 done", done, m_done);
      chk(err == m_err, "R9 err", err, m_err);
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'((seed + i * 13 + (i >> 3)) & 255);
  endfunction

  task automatic load(input int ln, input int seed, input int nw);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      for (int l = 0; l < 4; l++) begin
        int p;
        p = w * 4 + l;
        if (w >= 512)   d[8*l +: 8] = 8'hFF;
        else if (p == 0) d[8*l +: 8] = 8'(ln & 255);
        else if (p == 1) d[8*l +: 8] = 8'((ln >> 8) & 255);
        else            d[8*l +: 8] = fbyte(seed, p - 2);
      end
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic send(input bit pad, input int ln, input bit stall, input bit inject, input string req);
    int expn, k;
    expn = (pad && ln < 60) ? 60 : ln;
    pad_en = pad; start = 1'b1; nacc = 0;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (m_busy) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = stall ? lfsr[0] : 1'b1;
      if (inject && k == 3) begin wr_en = 1'b1; wr_data = 32'h5A5A_A5A5; end
      else wr_en = 1'b0;
      k++;
      @(negedge clk);
    end
    wr_en = 1'b0; tx_ready = 1'b1;
    @(negedge clk);
    chk(nacc == expn, req, nacc, expn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0 && tx_valid == 0 && tx_last == 0 && done == 0 && err == 0,
        "R11 reset outputs", {busy, tx_valid, tx_last, done, err}, 0);
    rst_n = 1'b1;
    monitor_on = 1;
    @(negedge clk);

    load(100, 7, 26);   send(1, 100, 0, 0, "R6 count len100 pad");
    load(10, 40, 3);    send(1, 10, 1, 0, "R5 count len10 padded stale");
    load(10, 90, 3);    send(0, 10, 0, 0, "R6 count len10 nopad");
    load(60, 3, 16);    send(1, 60, 1, 0, "R6 count len60 pad");
    load(61, 5, 16);    send(0, 61, 0, 0, "R6 count len61");
    load(1, 9, 1);      send(0, 1, 0, 0, "R3 count len1");
    load(0, 0, 1);      send(0, 0, 0, 0, "R7 count zero length");
    send(0, 0, 0, 0, "R7 count empty buffer");
    load(0, 0, 1);      send(1, 0, 1, 0, "R5 count zero length padded");
    load(8, 21, 520);   send(0, 8, 0, 0, "R10 count after overfill");
    load(2046, 77, 512); send(0, 2046, 1, 0, "R6 count full buffer");
    load(40, 11, 11);   send(0, 40, 1, 1, "R9 count with write during busy");
    chk(err == 1'b1, "R9 err set", err, 1);
    load(20, 33, 6);    send(1, 20, 0, 0, "R8 count next frame after done");
    chk(err == 1'b1, "R9 err sticky", err, 1);

    monitor_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule